// File: doc/BRIEF.md
# Programmable-Duty Frequency Doubler

This block derives a clock at twice the rate of a slow reference clock. It runs on a fast sampling clock whose period is exactly 1/32 of the reference period. It synchronizes the reference, finds its rising edges, and restarts a 5-bit phase count at each one. From that count it builds two output pulses per reference period. The first pulse lies in the reference-high half and the second in the reference-low half. Each pulse has its own high time, set in 1/32-reference-period steps.

A small write-only register bank is reached through an address/data/write-enable port. The duty register is copied into an active copy only when a reference rising edge is detected, so a new setting never cuts a pulse short. The mode register can switch the doubler off. The routing register enables each of the two gated outputs on its own. Routing and mode act on the fast cycle after the write.

A lock state machine has three states: `ST_IDLE`, `ST_ARMED` and `ST_LOCKED`. It moves from `ST_IDLE` to `ST_ARMED` on the first detected edge (transition *first edge*). It moves from `ST_ARMED` to `ST_LOCKED` on the next detected edge (transition *second edge*). From `ST_ARMED` or `ST_LOCKED` it returns to `ST_IDLE` when no edge arrives within `LOSS_LIMIT` fast cycles (transition *timeout*).

Top module: `clkdbl_top`

## Requirements
- R1: While locked and enabled, each output is high for one pulse starting at phase 0 and one starting at phase 16 of every reference period. Phase 0 is the fourth fast cycle after the fast edge at which the reference is first seen high (two synchronizer stages, edge detect, output register).
- R2: The first pulse lasts duty[5:3]+1 fast cycles, plus 8 when duty[7] is 1. The range is 1 to 16 fast cycles, i.e. 6.25% to 100% of a doubled cycle.
- R3: The second pulse lasts duty[2:0]+1 fast cycles, plus 8 when duty[6] is 1. It is independent of the first pulse's setting.
- R4: A duty write takes effect at the next reference rising edge. The rest of the current reference period keeps the old pulse widths.
- R5: After reset, both outputs stay low and `locked` stays 0 until a second rising edge has been seen. `locked` goes to 1 three fast cycles after the fast edge at which the second rising reference level is first sampled.
- R6: If no reference rising edge arrives for `LOSS_LIMIT` (default 48) fast cycles, `locked` drops, the outputs go low, and two new edges are needed to lock again.
- R7: Mode register (address 1) bit 4 at 1 forces both outputs low. At 0 it allows them.
- R8: Routing register (address 2): output A is enabled only when bits [5:4] equal 01, and output B only when bits [7:6] equal 01. Any other code holds that output low from the next fast cycle.
- R9: Writes to address 3 change nothing. The duty register is at address 0.
- R10: Reset clears both outputs and `locked`. Reset sets duty to 0x3F (both pulses at 8 cycles), mode to 0x00 and routing to 0x50 (both outputs enabled).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Sampling clock, 32 cycles per reference period |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_in | input | 1 | Reference clock, asynchronous to clk_fast |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| dbl_out_a | output | 1 | Doubled clock, gated output A |
| dbl_out_b | output | 1 | Doubled clock, gated output B |
| locked | output | 1 | Two consecutive reference edges seen |

## Verification
The assertions assume the reference period is exactly 32 fast cycles and never longer than `LOSS_LIMIT`. Where the reference is stopped, they assume it stays low long enough to force a timeout. They also assume a write is a one-cycle strobe with stable address and data. The stimulus drives the reference from a single counter of fast-clock falling edges, 16 high and 16 low. It writes registers only at step 10 of a period, well away from the edge-detect window. It stops the reference only for a fixed 64-cycle gap, which is well beyond the timeout.

// File: rtl/clkdbl_pkg.sv
package clkdbl_pkg;
    localparam int PH_W    = 5;
    localparam int TICKS   = 1 << PH_W;
    localparam int HALF    = TICKS / 2;
    localparam int HI_ADD  = HALF / 2;
    localparam int ADDR_W  = 2;
    localparam int DATA_W  = 8;

    localparam logic [ADDR_W-1:0] A_DUTY  = 2'd0;
    localparam logic [ADDR_W-1:0] A_MODE  = 2'd1;
    localparam logic [ADDR_W-1:0] A_ROUTE = 2'd2;

    localparam logic [DATA_W-1:0] DUTY_RST  = 8'h3F;
    localparam logic [DATA_W-1:0] MODE_RST  = 8'h00;
    localparam logic [DATA_W-1:0] ROUTE_RST = 8'h50;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_LOCKED = 2'd2
    } lock_state_t;
endpackage

// File: rtl/clkdbl_sync.sv
module clkdbl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    logic [STAGES-1:0] shreg;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            prev_q <= 1'b0;
        end else begin
            shreg  <= {shreg[STAGES-2:0], async_in};
            prev_q <= shreg[STAGES-1];
        end
    end

    assign rise_o = shreg[STAGES-1] & ~prev_q;
endmodule

// File: rtl/clkdbl_regs.sv
module clkdbl_regs
    import clkdbl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load_i,
    output logic [DATA_W-1:0] duty_act_o,
    output logic              en_a_o,
    output logic              en_b_o
);
    logic [DATA_W-1:0] duty_q, mode_q, route_q, act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_q  <= DUTY_RST;
            mode_q  <= MODE_RST;
            route_q <= ROUTE_RST;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_DUTY:  duty_q  <= wr_data;
                A_MODE:  mode_q  <= wr_data;
                A_ROUTE: route_q <= wr_data;
                default: ;
            endcase
        end
    end

    // active copy changes only on a detected reference edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      act_q <= DUTY_RST;
        else if (load_i) act_q <= duty_q;
    end

    always_comb begin
        duty_act_o = act_q;
        en_a_o     = ~mode_q[4] && (route_q[5:4] == 2'b01);
        en_b_o     = ~mode_q[4] && (route_q[7:6] == 2'b01);
    end
endmodule

// File: rtl/clkdbl_fsm.sv
module clkdbl_fsm
    import clkdbl_pkg::*;
#(
    parameter int LOSS_LIMIT = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rise_i,
    output logic [PH_W-1:0] phase_o,
    output logic            locked_o
);
    localparam int TW = $clog2(LOSS_LIMIT + 1);
    localparam logic [TW-1:0] T_LAST = TW'(LOSS_LIMIT - 1);

    lock_state_t     state_q, state_d;
    logic [PH_W-1:0] phase_q;
    logic [TW-1:0]   tcnt_q;
    logic            lost;

    assign lost = (tcnt_q == T_LAST) && !rise_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            tcnt_q  <= '0;
        end else if (rise_i) begin
            phase_q <= '0;
            tcnt_q  <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
            if (tcnt_q != T_LAST) tcnt_q <= tcnt_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (rise_i) state_d = ST_ARMED;
            ST_ARMED:  if (rise_i) state_d = ST_LOCKED;
                       else if (lost) state_d = ST_IDLE;
            ST_LOCKED: if (lost) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        locked_o = (state_q == ST_LOCKED);
        phase_o  = phase_q;
    end
endmodule

// File: rtl/clkdbl_wave.sv
module clkdbl_wave
    import clkdbl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PH_W-1:0]   phase_i,
    input  logic              locked_i,
    input  logic [DATA_W-1:0] duty_i,
    output logic              wave_o
);
    logic [1:0] hit;

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [2:0]    code;
        logic          flag;
        logic [PH_W-1:0] high_t;
        logic [PH_W-1:0] offs;
        assign code   = duty_i[3*(1-h) +: 3];
        assign flag   = duty_i[7-h];
        assign high_t = PH_W'(code) + PH_W'(1) + (flag ? PH_W'(HI_ADD) : '0);
        assign offs   = {1'b0, phase_i[PH_W-2:0]};
        assign hit[h] = (phase_i[PH_W-1] == 1'(h)) && (offs < high_t);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wave_o <= 1'b0;
        else        wave_o <= locked_i && (|hit);
    end
endmodule

// File: rtl/clkdbl_top.sv
module clkdbl_top
    import clkdbl_pkg::*;
#(
    parameter int LOSS_LIMIT  = 48,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_fast,
    input  logic              rst_n,
    input  logic              ref_clk_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              dbl_out_a,
    output logic              dbl_out_b,
    output logic              locked
);
    logic              rise;
    logic [PH_W-1:0]   phase;
    logic [DATA_W-1:0] duty_act;
    logic              en_a, en_b, wave, lk;

    clkdbl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk_fast), .rst_n(rst_n), .async_in(ref_clk_in), .rise_o(rise)
    );

    clkdbl_regs u_regs (
        .clk(clk_fast), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .load_i(rise), .duty_act_o(duty_act),
        .en_a_o(en_a), .en_b_o(en_b)
    );

    clkdbl_fsm #(.LOSS_LIMIT(LOSS_LIMIT)) u_fsm (
        .clk(clk_fast), .rst_n(rst_n), .rise_i(rise),
        .phase_o(phase), .locked_o(lk)
    );

    clkdbl_wave u_wave (
        .clk(clk_fast), .rst_n(rst_n), .phase_i(phase), .locked_i(lk),
        .duty_i(duty_act), .wave_o(wave)
    );

    assign dbl_out_a = wave & en_a;
    assign dbl_out_b = wave & en_b;
    assign locked    = lk;
endmodule

// File: rtl/clkdbl_chk.sv
module clkdbl_chk
    import clkdbl_pkg::*;
(
    input logic              clk_fast,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              dbl_out_a,
    input logic              dbl_out_b,
    input logic              locked,
    input logic              rise,
    input logic [PH_W-1:0]   phase,
    input logic [DATA_W-1:0] duty_act
);
    // R1
    phase_restart_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        $past(rise) |-> (phase == '0));

    // R4
    duty_hold_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !$past(rise) |-> $stable(duty_act));

    // R5
    lock_on_edge_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        $rose(locked) |-> $past(rise));

    // R5
    quiet_unlocked_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (!locked && !$past(locked)) |-> (!dbl_out_a && !dbl_out_b));

    // R7
    mode_off_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (wr_en && wr_addr == A_MODE && wr_data[4]) |=> (!dbl_out_a && !dbl_out_b));

    // R8
    route_a_off_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (wr_en && wr_addr == A_ROUTE && wr_data[5:4] != 2'b01) |=> !dbl_out_a);

    // R8
    route_b_off_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (wr_en && wr_addr == A_ROUTE && wr_data[7:6] != 2'b01) |=> !dbl_out_b);
endmodule

bind clkdbl_top clkdbl_chk u_chk (
    .clk_fast(clk_fast), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dbl_out_a(dbl_out_a), .dbl_out_b(dbl_out_b),
    .locked(locked), .rise(rise), .phase(phase), .duty_act(duty_act)
);

// File: tb/clkdbl_top_tb.sv
module clkdbl_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       out_a, out_b, lk;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [7:0] duty_m  = 8'h3F;
    logic [7:0] mode_m  = 8'h00;
    logic [7:0] route_m = 8'h50;
    logic [7:0] cfg_old = 8'h3F;
    bit         lock_old = 0;
    int         n_rises = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkdbl_top u_dut (
        .clk_fast(clk), .rst_n(rst_n), .ref_clk_in(ref_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .dbl_out_a(out_a),
        .dbl_out_b(out_b), .locked(lk)
    );

    function automatic bit wave_f(logic [7:0] d, int ph);
        int ha = int'(d[5:3]) + 1 + (d[7] ? 8 : 0);
        int hb = int'(d[2:0]) + 1 + (d[6] ? 8 : 0);
        if (ph < 16) return ph < ha;
        return (ph - 16) < hb;
    endfunction

    task automatic chk(input logic got, input logic exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // one reference period, 16 high / 16 low, optional write at step 10
    task automatic run_period(input bit do_wr, input logic [1:0] a,
                              input logic [7:0] d, input string tag);
        logic [7:0] cfg_new = duty_m;
        bit lock_new;
        n_rises++;
        lock_new = (n_rises >= 2);
        for (int j = 0; j < 32; j++) begin
            @(negedge clk);
            begin
                int ph = (j + 28) % 32;
                logic [7:0] cf = (j < 4) ? cfg_old : cfg_new;
                bit wl = (j < 4) ? lock_old : lock_new;
                bit lx = (j < 3) ? lock_old : lock_new;
                bit w  = wl && wave_f(cf, ph);
                bit ea = !mode_m[4] && route_m[5:4] == 2'b01;
                bit eb = !mode_m[4] && route_m[7:6] == 2'b01;
                chk(lk, lx, {tag, " R5 lock"});
                chk(out_a, w && ea, {tag, " R1 R2 R3 out_a"});
                chk(out_b, w && eb, {tag, " R1 R2 R3 out_b"});
            end
            ref_in = (j < 16);
            if (j == 10 && do_wr) begin
                wr_en = 1'b1; wr_addr = a; wr_data = d;
                case (a)
                    2'd0: duty_m  = d;
                    2'd1: mode_m  = d;
                    2'd2: route_m = d;
                    default: ;
                endcase
            end
            if (j == 11) wr_en = 1'b0;
        end
        cfg_old  = cfg_new;
        lock_old = lock_new;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(out_a, 1'b0, "R10 reset out_a");
        chk(out_b, 1'b0, "R10 reset out_b");
        chk(lk, 1'b0, "R10 reset locked");
        rst_n = 1'b1;

        // lock-up with reset duty value
        run_period(0, 2'd0, 8'h00, "R10 R5 first");
        run_period(0, 2'd0, 8'h00, "R10 R5 second");
        run_period(0, 2'd0, 8'h00, "R10 steady");

        // sweep every duty code; each write lands mid-period (R4)
        for (int d = 0; d < 256; d++)
            run_period(1, 2'd0, 8'(d), "R4 sweep");
        run_period(1, 2'd0, 8'hA3, "R4 sweep");
        run_period(0, 2'd0, 8'h00, "R2 R3 settle");

        // routing codes
        run_period(1, 2'd2, 8'h90, "R8 A only");
        run_period(1, 2'd2, 8'h40, "R8 B only");
        run_period(1, 2'd2, 8'hF0, "R8 none");
        run_period(1, 2'd2, 8'h50, "R8 both");

        // mode gating
        run_period(1, 2'd1, 8'h10, "R7 off");
        run_period(1, 2'd1, 8'hEF, "R7 on");
        run_period(1, 2'd1, 8'h00, "R7 clear");

        // unused address: data would kill outputs if it landed
        run_period(1, 2'd3, 8'h10, "R9 ignored");
        run_period(0, 2'd0, 8'h00, "R9 after");

        // stop the reference
        for (int j = 0; j < 64; j++) begin
            @(negedge clk);
            ref_in = 1'b0;
        end
        chk(lk, 1'b0, "R6 lost locked");
        chk(out_a, 1'b0, "R6 lost out_a");
        chk(out_b, 1'b0, "R6 lost out_b");
        n_rises  = 0;
        lock_old = 0;
        run_period(0, 2'd0, 8'h00, "R6 relock first");
        run_period(0, 2'd0, 8'h00, "R6 relock second");
        run_period(0, 2'd0, 8'h00, "R6 relock steady");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule